// File: doc/BRIEF.md
# Threadblock Placement Dispatcher

This block takes an ordered stream of threadblocks, each given as an identifier and a thread count, and hands every block whole to one of `NUM_CORES` compute cores. For each core it keeps two occupancy counters, resident blocks and resident threads. A block goes to a core only when that core has room for it under every limit: a fixed ceiling of resident blocks, a fixed ceiling of resident threads, and a programmable thread cap. When a core finishes a block it raises a one-cycle retire pulse and gives that block's thread count at the same time.

A configuration bit selects the placement policy. In the *spread* policy, consecutive blocks go to consecutive cores in rotation, so neighbouring blocks run at the same time on different cores. In the *keep* policy, consecutive blocks stay on one core until that core cannot take the next block. The pointer then moves on to the following core and wraps after the last one. Neighbouring blocks therefore run close together in time on the same core. Blocks always leave in the order they arrived.

The controller is a three-state machine. **ST_IDLE** waits for an input block, and the transition *accept* (input valid while idle) latches the block. **ST_CHECK** tests the core under the pointer. The transition *fit* moves to ST_OFFER. The transition *skip* stays in ST_CHECK and advances the pointer by one core; it is taken only under the keep policy when the core lacks room. The transition *stall* stays in ST_CHECK with the pointer unchanged, under the spread policy when the core lacks room. **ST_OFFER** drives the dispatch valid of the target core. The transition *commit* (that core's ready is high) charges the block to the core and returns to ST_IDLE. Under the spread policy, commit also advances the pointer.

Top module: `lad_dispatcher`

## Requirements
- R1: After reset, `in_ready` is 1, every `dsp_valid` bit is 0, all occupancy counters are zero and the pointer selects core 0, so the first block goes to core 0.
- R2: Blocks are dispatched strictly in arrival order. After a block is accepted, `in_ready` stays 0 until that block has been handed to a core, and `dsp_id` carries the accepted identifier.
- R3: A block is offered to exactly one core (at most one `dsp_valid` bit is set). While that core holds its ready low, the offer keeps the same core and the same `dsp_id`.
- R4: A core never holds more than `MAX_BLKS` (8) blocks. A block aimed at a core that already has 8 waits until that core retires one.
- R5: A core never holds more than its thread limit. A block fits when the resident threads plus the block's threads are at most the limit, and an exact fill is allowed. The hardware limit is `MAX_THR` (1536).
- R6: `cfg_cap` sets the thread limit per core: code 0 gives 64, 1 gives 128, 2 gives 256, 3 gives 512, 4 gives 1024, and codes 5 to 7 give the hardware limit of 1536.
- R7: With `cfg_keep`=0 (spread), each dispatch goes to the core after the previous one, wrapping from core `NUM_CORES-1` to core 0.
- R8: With `cfg_keep`=0, if the target core has no room, the dispatcher stalls on that core even when another core has room. It dispatches there once that core's retires free enough room.
- R9: With `cfg_keep`=1 (keep), blocks stay on the current core while they fit. When a block does not fit, the pointer advances one core per cycle, wrapping after the last core, until a core fits.
- R10: A retire pulse on a core lowers that core's block count by one and its thread count by `ret_thr` of that core, both in the same cycle.
- R11: When the target core fits, its `dsp_valid` rises one cycle after the accepting edge, plus one more cycle for each core skipped under the keep policy. `in_ready` returns one cycle after the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_keep | input | 1 | Policy: 0 spread across cores, 1 keep on one core |
| cfg_cap | input | 3 | Per-core thread cap code |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Dispatcher can accept a block |
| in_id | input | ID_W | Identifier of the input block |
| in_thr | input | THR_W | Thread count of the input block |
| dsp_valid | output | NUM_CORES | Per-core dispatch offer |
| dsp_ready | input | NUM_CORES | Per-core acceptance of the offer |
| dsp_id | output | ID_W | Identifier of the offered block |
| ret_pulse | input | NUM_CORES | Per-core one-cycle retire pulse |
| ret_thr | input | NUM_CORES*THR_W | Per-core thread count of the retiring block |

## Verification
A block accepted on edge E is tested against the target core at edge E+1. If it fits, its offer is visible after that edge. Each core skipped under the keep policy adds one cycle, and a retire changes the fit result from the edge after its pulse. The bench drives and samples on falling edges. For every block it predicts the number of idle cycles from its own occupancy model, checks that `dsp_valid` is zero for exactly that many samples, then checks the target core and identifier, then checks that `in_ready` is back one sample after the handshake. Stall cases are checked by sampling for a fixed number of cycles with no offer, then releasing room with a retire and checking that the offer comes out on the next-but-one sample.

// File: rtl/lad_pkg.sv
package lad_pkg;
    localparam int unsigned LAD_HW_BLKS    = 8;
    localparam int unsigned LAD_HW_THREADS = 1536;
    localparam int unsigned LAD_CAP_BASE   = 64;
    localparam int unsigned LAD_CAP_STEPS  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_OFFER = 2'd2
    } lad_state_e;
endpackage

// File: rtl/lad_cap_decode.sv
module lad_cap_decode #(
    parameter int THR_W     = 11,
    parameter int MAX_THR   = 1536,
    parameter int CAP_BASE  = 64,
    parameter int CAP_STEPS = 5
) (
    input  logic [2:0]       cap_sel,
    output logic [THR_W-1:0] thr_limit
);
    localparam int RAW_W = THR_W + 8;

    logic [RAW_W-1:0] raw;

    // Codes below CAP_STEPS double from CAP_BASE; the rest mean no extra cap
    always_comb begin
        if (cap_sel < 3'(CAP_STEPS)) begin
            raw = RAW_W'(CAP_BASE) << cap_sel;
        end else begin
            raw = RAW_W'(MAX_THR);
        end
        if (raw > RAW_W'(MAX_THR)) begin
            raw = RAW_W'(MAX_THR);
        end
        thr_limit = raw[THR_W-1:0];
    end
endmodule

// File: rtl/lad_core_occ.sv
module lad_core_occ #(
    parameter int MAX_BLKS = 8,
    parameter int THR_W    = 11,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [THR_W-1:0] add_thr,
    input  logic             sub_en,
    input  logic [THR_W-1:0] sub_thr,
    input  logic [THR_W-1:0] req_thr,
    input  logic [THR_W-1:0] thr_limit,
    output logic             fits,
    output logic [CNT_W-1:0] blk_cnt,
    output logic [THR_W-1:0] thr_cnt
);
    logic [THR_W:0] thr_sum;

    // Dispatch and retire may land in the same cycle; both apply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            thr_cnt <= '0;
        end else begin
            blk_cnt <= blk_cnt + CNT_W'(add_en) - CNT_W'(sub_en);
            thr_cnt <= thr_cnt + (add_en ? add_thr : '0) - (sub_en ? sub_thr : '0);
        end
    end

    always_comb begin
        thr_sum = {1'b0, thr_cnt} + {1'b0, req_thr};
        fits    = (blk_cnt < CNT_W'(MAX_BLKS)) && (thr_sum <= {1'b0, thr_limit});
    end
endmodule

// File: rtl/lad_dispatcher.sv
module lad_dispatcher
    import lad_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 8,
    parameter int THR_W     = 11,
    parameter int MAX_BLKS  = LAD_HW_BLKS,
    parameter int MAX_THR   = LAD_HW_THREADS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_keep,
    input  logic [2:0]                 cfg_cap,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ID_W-1:0]            in_id,
    input  logic [THR_W-1:0]           in_thr,
    output logic [NUM_CORES-1:0]       dsp_valid,
    input  logic [NUM_CORES-1:0]       dsp_ready,
    output logic [ID_W-1:0]            dsp_id,
    input  logic [NUM_CORES-1:0]       ret_pulse,
    input  logic [NUM_CORES*THR_W-1:0] ret_thr
);
    localparam int PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int CNT_W = $clog2(MAX_BLKS + 1);
    localparam int LAST  = NUM_CORES - 1;

    lad_state_e state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_wrap;
    logic [ID_W-1:0]  hold_id_q;
    logic [THR_W-1:0] hold_thr_q;
    logic [THR_W-1:0] thr_limit;
    logic [NUM_CORES-1:0] fits_vec;
    logic cur_fits, commit;
    logic [NUM_CORES*CNT_W-1:0] occ_blk_flat;
    logic [NUM_CORES*THR_W-1:0] occ_thr_flat;

    lad_cap_decode #(
        .THR_W    (THR_W),
        .MAX_THR  (MAX_THR),
        .CAP_BASE (LAD_CAP_BASE),
        .CAP_STEPS(LAD_CAP_STEPS)
    ) u_cap (
        .cap_sel  (cfg_cap),
        .thr_limit(thr_limit)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lad_core_occ #(
            .MAX_BLKS(MAX_BLKS),
            .THR_W   (THR_W),
            .CNT_W   (CNT_W)
        ) u_occ (
            .clk      (clk),
            .rst_n    (rst_n),
            .add_en   (commit && (ptr_q == PTR_W'(c))),
            .add_thr  (hold_thr_q),
            .sub_en   (ret_pulse[c]),
            .sub_thr  (ret_thr[c*THR_W +: THR_W]),
            .req_thr  (hold_thr_q),
            .thr_limit(thr_limit),
            .fits     (fits_vec[c]),
            .blk_cnt  (occ_blk_flat[c*CNT_W +: CNT_W]),
            .thr_cnt  (occ_thr_flat[c*THR_W +: THR_W])
        );
    end

    always_comb begin
        ptr_wrap = (ptr_q == PTR_W'(LAST)) ? '0 : ptr_q + 1'b1;
        cur_fits = fits_vec[ptr_q];
        commit   = (state_q == ST_OFFER) && dsp_ready[ptr_q];
    end

    // State register, pointer and held block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            hold_id_q  <= '0;
            hold_thr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && in_valid) begin
                hold_id_q  <= in_id;
                hold_thr_q <= in_thr;
            end
            if (state_q == ST_CHECK && !cur_fits && cfg_keep) begin
                ptr_q <= ptr_wrap;
            end else if (commit && !cfg_keep) begin
                ptr_q <= ptr_wrap;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)          state_d = ST_CHECK;
            ST_CHECK: if (cur_fits)          state_d = ST_OFFER;
            ST_OFFER: if (dsp_ready[ptr_q])  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        dsp_valid = '0;
        if (state_q == ST_OFFER) begin
            dsp_valid[ptr_q] = 1'b1;
        end
        dsp_id = hold_id_q;
    end
endmodule

// File: rtl/lad_dispatch_chk.sv
module lad_dispatch_chk #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 8,
    parameter int THR_W     = 11,
    parameter int MAX_BLKS  = 8,
    parameter int MAX_THR   = 1536,
    parameter int CNT_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_keep,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [NUM_CORES-1:0]       dsp_valid,
    input logic [NUM_CORES-1:0]       dsp_ready,
    input logic [ID_W-1:0]            dsp_id,
    input logic [NUM_CORES-1:0]       ret_pulse,
    input logic [NUM_CORES*THR_W-1:0] ret_thr,
    input logic [NUM_CORES*CNT_W-1:0] blk_flat,
    input logic [NUM_CORES*THR_W-1:0] thr_flat
);
    logic [NUM_CORES-1:0] hs_vec, last_hs;
    logic spread_seen;

    assign hs_vec = dsp_valid & dsp_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_hs     <= '0;
            spread_seen <= 1'b0;
        end else if (cfg_keep) begin
            spread_seen <= 1'b0;
        end else if (|hs_vec) begin
            last_hs     <= hs_vec;
            spread_seen <= 1'b1;
        end
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dsp_valid)); // R3

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dsp_valid & ~dsp_ready)) |=> (dsp_valid == $past(dsp_valid)) && (dsp_id == $past(dsp_id))); // R3

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_SPREAD_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hs_vec) && !cfg_keep && spread_seen) |->
            (hs_vec == {last_hs[NUM_CORES-2:0], last_hs[NUM_CORES-1]})); // R7

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        AST_BLK_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
            blk_flat[c*CNT_W +: CNT_W] <= CNT_W'(MAX_BLKS)); // R4

        AST_THR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
            thr_flat[c*THR_W +: THR_W] <= THR_W'(MAX_THR)); // R5

        AST_RETIRE_BLK: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_pulse[c] && !hs_vec[c]) |=>
                (blk_flat[c*CNT_W +: CNT_W] == $past(blk_flat[c*CNT_W +: CNT_W]) - 1'b1)); // R10

        AST_RETIRE_THR: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_pulse[c] && !hs_vec[c]) |=>
                (thr_flat[c*THR_W +: THR_W] ==
                 $past(thr_flat[c*THR_W +: THR_W]) - $past(ret_thr[c*THR_W +: THR_W]))); // R10
    end
endmodule

bind lad_dispatcher lad_dispatch_chk #(
    .NUM_CORES(NUM_CORES),
    .ID_W     (ID_W),
    .THR_W    (THR_W),
    .MAX_BLKS (MAX_BLKS),
    .MAX_THR  (MAX_THR),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_keep (cfg_keep),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .dsp_valid(dsp_valid),
    .dsp_ready(dsp_ready),
    .dsp_id   (dsp_id),
    .ret_pulse(ret_pulse),
    .ret_thr  (ret_thr),
    .blk_flat (occ_blk_flat),
    .thr_flat (occ_thr_flat)
);

// File: tb/lad_dispatcher_tb.sv
`timescale 1ns/1ps
module lad_dispatcher_tb;
    localparam int NC    = 4;
    localparam int ID_W  = 8;
    localparam int THR_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_keep = 1'b0;
    logic [2:0] cfg_cap = 3'd7;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [ID_W-1:0] in_id = '0;
    logic [THR_W-1:0] in_thr = '0;
    logic [NC-1:0] dsp_valid;
    logic [NC-1:0] dsp_ready = '1;
    logic [ID_W-1:0] dsp_id;
    logic [NC-1:0] ret_pulse = '0;
    logic [NC*THR_W-1:0] ret_thr = '0;

    int checks = 0;
    int errors = 0;
    int m_blk[NC];
    int m_thr[NC];
    int m_ptr = 0;
    int m_lim = 1536;

    always #4 clk = ~clk;

    lad_dispatcher #(.NUM_CORES(NC), .ID_W(ID_W), .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_keep(cfg_keep), .cfg_cap(cfg_cap),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_thr(in_thr),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_id(dsp_id),
        .ret_pulse(ret_pulse), .ret_thr(ret_thr)
    );

    function automatic int lim_of(int sel);
        return (sel < 5) ? (64 << sel) : 1536;
    endfunction

    function automatic bit room(int c, int thr);
        return (m_blk[c] < 8) && (m_thr[c] + thr <= m_lim);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit keep, int sel);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_keep = keep;
        cfg_cap = 3'(sel);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) begin
            m_blk[c] = 0;
            m_thr[c] = 0;
        end
        m_ptr = 0;
        m_lim = lim_of(sel);
        @(negedge clk);
    endtask

    // Hands one block over; returns at the falling edge after the accepting edge
    task automatic push(int id, int thr);
        check(in_ready == 1'b1, "R2 in_ready before push", int'(in_ready), 1);
        in_valid = 1'b1;
        in_id = ID_W'(id);
        in_thr = THR_W'(thr);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_offer(int core, int id, int idle, string tag);
        check(dsp_valid == '0, "R11 no offer in first check cycle", int'(dsp_valid), 0);
        for (int j = 0; j < idle; j++) begin
            @(negedge clk);
            check(dsp_valid == '0, "R11 no offer while seeking", int'(dsp_valid), 0);
        end
        @(negedge clk);
        check(dsp_valid == NC'(1 << core), tag, int'(dsp_valid), 1 << core);
        check(dsp_id == ID_W'(id), "R2 offered id", int'(dsp_id), id);
        @(negedge clk);
        check(dsp_valid == '0 && in_ready == 1'b1, "R11 ready after handshake",
              int'({in_ready, dsp_valid}), 1 << NC);
    endtask

    task automatic blk(int id, int thr, string tag);
        int c = m_ptr;
        int k = 0;
        if (cfg_keep) begin
            while (!room(c, thr) && k <= NC) begin
                c = (c + 1) % NC;
                k++;
            end
        end
        push(id, thr);
        expect_offer(c, id, k, tag);
        m_blk[c]++;
        m_thr[c] += thr;
        m_ptr = cfg_keep ? c : (c + 1) % NC;
    endtask

    task automatic retire(int c, int thr);
        ret_pulse = NC'(1 << c);
        ret_thr[c*THR_W +: THR_W] = THR_W'(thr);
        @(posedge clk);
        @(negedge clk);
        ret_pulse = '0;
        m_blk[c]--;
        m_thr[c] -= thr;
    endtask

    task automatic expect_stall(int cycles, string tag);
        for (int j = 0; j < cycles; j++) begin
            @(negedge clk);
            check(dsp_valid == '0, tag, int'(dsp_valid), 0);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state and first placement
        do_reset(1'b0, 7);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(dsp_valid == '0, "R1 no offer after reset", int'(dsp_valid), 0);
        blk(1, 100, "R1 first block to core 0");

        // R7: spread rotation with varied sizes, cap code 4
        do_reset(1'b0, 4);
        for (int i = 0; i < 12; i++) blk(10 + i, (i * 7) % 60 + 1, "R7 spread target");

        // R3: offer held while the core is not ready
        do_reset(1'b0, 7);
        dsp_ready = '0;
        push(7, 10);
        check(dsp_valid == '0, "R11 no offer in first check cycle", int'(dsp_valid), 0);
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            check(dsp_valid == 4'b0001 && dsp_id == 8'd7, "R3 offer held",
                  int'(dsp_valid), 1);
            check(in_ready == 1'b0, "R2 no accept while pending", int'(in_ready), 0);
            @(negedge clk);
        end
        dsp_ready = '1;
        @(negedge clk);
        check(dsp_valid == '0 && in_ready == 1'b1, "R3 released after ready",
              int'(dsp_valid), 0);

        // R4: block ceiling of 8 per core
        do_reset(1'b0, 7);
        for (int i = 0; i < 32; i++) blk(i, 16, "R4 fill target");
        push(100, 16);
        expect_stall(12, "R4 ninth block waits");
        retire(0, 16);
        check(dsp_valid == '0, "R10 fit seen after retire edge", int'(dsp_valid), 0);
        @(negedge clk);
        check(dsp_valid == 4'b0001 && dsp_id == 8'd100, "R4 dispatch after retire",
              int'(dsp_valid), 1);
        @(negedge clk);

        // R8: spread stalls on a full target though others have room
        do_reset(1'b0, 0);
        for (int i = 0; i < 4; i++) blk(20 + i, 64, "R8 fill cores");
        retire(2, 64);
        push(30, 64);
        expect_stall(12, "R8 stall, no skip");
        retire(0, 64);
        check(dsp_valid == '0, "R8 no early offer", int'(dsp_valid), 0);
        @(negedge clk);
        check(dsp_valid == 4'b0001 && dsp_id == 8'd30, "R8 offer to stalled core",
              int'(dsp_valid), 1);
        @(negedge clk);

        // R6: cap codes, four blocks fill a core exactly, the fifth moves on
        for (int sel = 0; sel < 8; sel++) begin
            do_reset(1'b1, sel);
            for (int i = 0; i < 5; i++) blk(40 + i, lim_of(sel) / 4, "R6 cap code placement");
        end

        // R5: hardware thread ceiling with an exact fill
        do_reset(1'b1, 7);
        blk(50, 1024, "R5 first part");
        blk(51, 512, "R5 exact fill");
        blk(52, 1, "R5 overflow moves on");

        // R9: keep policy advances and wraps
        do_reset(1'b1, 0);
        for (int i = 0; i < 4; i++) blk(60 + i, 64, "R9 advance on full core");
        retire(0, 64);
        blk(64, 64, "R9 wrap to core 0");

        // R10: retire frees one block and exactly its threads
        do_reset(1'b1, 0);
        for (int i = 0; i < 8; i++) blk(70 + i, 8, "R10 fill core 0");
        retire(0, 8);
        blk(80, 8, "R10 freed slot on core 0");
        retire(0, 8);
        blk(81, 16, "R10 too few threads freed");

        finish_run();
    end
endmodule